// File: doc/BRIEF.md
# Lockable Protected Memory Region Enforcer

The enforcer decides, for every memory access, whether it may go ahead, based on a small set of protected physical regions that boot firmware programs. Region 0 belongs to the main processor. Regions 1 and up each belong to one coprocessor, whose requester ID has the same number. Each region is a half-open span of 16 KiB pages, given by a base page and a limit page.

While boot is running, firmware writes the region bounds through a config port and may load code into the regions freely. A boot-done pulse sets a sticky lock. From that point the bounds are frozen until reset. Writes that land in any region are refused. Execute accesses must fall in the requester's own region. Every access gets a registered grant-or-deny answer one cycle later, together with a 2-bit fault code.

The lock cannot be undone, and bounds that overlap are reported when the lock is taken. This lets a system integrator verify the boot sequence once, and then rely on the region map for the rest of the run.

Top module: `pmr_enforcer`

## Requirements
- R1: After reset no region is enabled, `lock_o` is 0, and `resp_vld_o`, `resp_deny_o`, `resp_fault_o` and `cfg_err_o` are all 0.
- R2: While unlocked, a config write (`cfg_we_i`) loads `cfg_pg_i` into the base (`cfg_lim_i`=0) or the limit (`cfg_lim_i`=1) of region `cfg_idx_i`. The new value applies to accesses from the next cycle on. A write with an index of N_CP+1 or more has no effect.
- R3: A region is enabled only when its limit is greater than its base. An address hits it when its page number (address bits above bit 13) is at least base and below limit.
- R4: While unlocked, every access is granted with fault code 0.
- R5: A `boot_done_i` pulse sets `lock_o` from the next cycle on. Only reset clears it, and further pulses have no effect.
- R6: While locked, config writes leave the bounds unchanged, and `cfg_err_o` pulses in the next cycle. If no access arrives in the same cycle, the response is a deny with fault code 3.
- R7: While locked, a write access (type 1) that hits any enabled region is denied with fault code 1.
- R8: While locked, a privileged execute access (type 2) from requester 0 is denied with fault code 2 unless the lowest-index region it hits is region 0. An unprivileged execute from requester 0 is not restricted.
- R9: While locked, an execute access from a requester k other than 0 is denied with fault code 2 unless the lowest-index region it hits is region k. This holds whatever the privilege.
- R10: When regions overlap, the one with the lowest index decides the result. A boot-done pulse that arrives while unlocked and while two enabled regions overlap still sets the lock, and also pulses `cfg_err_o` in the next cycle.
- R11: One cycle after an access, `resp_vld_o` is 1 and `resp_fault_o` is nonzero exactly when `resp_deny_o` is 1. Reads (type 0) and type 3 are always granted. In a cycle with no access and no locked config write, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_idx_i | input | IDX_W | Region index for the config write |
| cfg_lim_i | input | 1 | 0 writes the base, 1 writes the limit |
| cfg_pg_i | input | PG_W | Page number to store |
| boot_done_i | input | 1 | End-of-boot pulse that takes the lock |
| acc_vld_i | input | 1 | Access request valid |
| acc_addr_i | input | ADDR_W | Physical address of the access |
| acc_type_i | input | 2 | 0 read, 1 write, 2 execute, 3 treated as read |
| acc_priv_i | input | 1 | Privileged access |
| acc_src_i | input | IDX_W | Requester ID (0 = main processor) |
| resp_vld_o | output | 1 | Registered response valid |
| resp_deny_o | output | 1 | Access or config write refused |
| resp_fault_o | output | 2 | 0 none, 1 write to protected, 2 execute outside, 3 config after lock |
| cfg_err_o | output | 1 | Pulse for a locked config write or overlap at lock time |
| lock_o | output | 1 | Sticky lock state |

## Verification
A corrupted base or limit register would show up as a wrong grant or deny on the very next access near that boundary. A lock bit that failed to set, or cleared on its own, would show on `lock_o` in the cycle after the fault, and on the next protected write, which would then be granted. The bench checks page boundaries on both sides of each limit, overlaps resolved by lowest index, and config writes attempted after lock. Each response and error pulse is compared exactly one cycle after its stimulus, so a stale or early register is caught in the cycle it goes wrong.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_type_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_WR_PROT  = 2'd1,
    FLT_EX_OUT   = 2'd2,
    FLT_CFG_LOCK = 2'd3
  } fault_e;
endpackage

// File: rtl/pmr_cfg_regs.sv
module pmr_cfg_regs #(
  parameter int N_REG = 3,
  parameter int IDX_W = 2,
  parameter int PG_W  = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic            cfg_lim_i,
  input  logic [PG_W-1:0] cfg_pg_i,
  input  logic            boot_done_i,
  output logic [PG_W-1:0] base_o [N_REG],
  output logic [PG_W-1:0] lim_o  [N_REG],
  output logic [N_REG-1:0] en_o,
  output logic            lock_o,
  output logic            cfg_lock_wr_o,
  output logic            cfg_err_o
);
  logic [PG_W-1:0] base_q [N_REG];
  logic [PG_W-1:0] lim_q  [N_REG];
  logic            lock_q, err_q, ovl;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic sel;
    assign sel = cfg_we_i && !lock_q && (cfg_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else if (sel) begin
        if (cfg_lim_i) lim_q[g]  <= cfg_pg_i;
        else           base_q[g] <= cfg_pg_i;
      end
    end

    assign en_o[g]   = lim_q[g] > base_q[g];
    assign base_o[g] = base_q[g];
    assign lim_o[g]  = lim_q[g];

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> ($stable(base_q[g]) && $stable(lim_q[g]))); // R6
  end

  // pairwise overlap of enabled regions, evaluated when the lock is taken
  always_comb begin
    ovl = 1'b0;
    for (int i = 0; i < N_REG; i++) begin
      for (int j = i + 1; j < N_REG; j++) begin
        if (en_o[i] && en_o[j] && (base_q[i] < lim_q[j]) && (base_q[j] < lim_q[i]))
          ovl = 1'b1;
      end
    end
  end

  assign cfg_lock_wr_o = cfg_we_i && lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (boot_done_i) lock_q <= 1'b1;
      err_q <= cfg_lock_wr_o || (boot_done_i && !lock_q && ovl);
    end
  end

  assign lock_o    = lock_q;
  assign cfg_err_o = err_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R5
  AST_LOCK_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_i |=> lock_q); // R5
endmodule

// File: rtl/pmr_region_match.sv
module pmr_region_match #(
  parameter int N_REG = 3,
  parameter int IDX_W = 2,
  parameter int PG_W  = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PG_W-1:0]  base_i [N_REG],
  input  logic [PG_W-1:0]  lim_i  [N_REG],
  input  logic [N_REG-1:0] en_i,
  input  logic [PG_W-1:0]  pg_i,
  output logic             hit_any_o,
  output logic [IDX_W-1:0] first_idx_o
);
  logic [N_REG-1:0] hit, first_oh;

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    assign hit[g] = en_i[g] && (pg_i >= base_i[g]) && (pg_i < lim_i[g]);
  end

  // isolate lowest set bit: lowest index wins on overlap
  assign first_oh  = hit & (~hit + N_REG'(1));
  assign hit_any_o = |hit;

  always_comb begin
    first_idx_o = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit[i]) first_idx_o = IDX_W'(i);
    end
  end

  AST_FIRST_CONSISTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_any_o |-> (first_oh[first_idx_o] && $onehot0(first_oh))); // R10
endmodule

// File: rtl/pmr_access_check.sv
module pmr_access_check
  import pmr_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_vld_i,
  input  logic [1:0]       acc_type_i,
  input  logic             acc_priv_i,
  input  logic [IDX_W-1:0] acc_src_i,
  input  logic             lock_i,
  input  logic             hit_any_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic             cfg_lock_wr_i,
  output logic             resp_vld_o,
  output logic             resp_deny_o,
  output logic [1:0]       resp_fault_o
);
  acc_type_e typ;
  fault_e    fault_d;
  logic      deny_d, vld_d, own_ok, ex_chk;
  logic      vld_q, deny_q;
  logic [1:0] fault_q;

  assign typ    = acc_type_e'(acc_type_i);
  assign own_ok = hit_any_i && (first_idx_i == acc_src_i);
  assign ex_chk = (acc_src_i == '0) ? acc_priv_i : 1'b1;
  assign vld_d  = acc_vld_i || cfg_lock_wr_i;

  always_comb begin
    deny_d  = 1'b0;
    fault_d = FLT_NONE;
    if (acc_vld_i) begin
      if (lock_i) begin
        case (typ)
          ACC_WR: if (hit_any_i) begin
            deny_d  = 1'b1;
            fault_d = FLT_WR_PROT;
          end
          ACC_EX: if (ex_chk && !own_ok) begin
            deny_d  = 1'b1;
            fault_d = FLT_EX_OUT;
          end
          default: ;
        endcase
      end
    end else if (cfg_lock_wr_i) begin
      deny_d  = 1'b1;
      fault_d = FLT_CFG_LOCK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      deny_q  <= 1'b0;
      fault_q <= 2'd0;
    end else begin
      vld_q   <= vld_d;
      deny_q  <= deny_d;
      fault_q <= fault_d;
    end
  end

  assign resp_vld_o   = vld_q;
  assign resp_deny_o  = deny_q;
  assign resp_fault_o = fault_q;

  AST_UNLOCKED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !lock_i) |=> (resp_vld_o && !resp_deny_o)); // R4
  AST_WR_PROT_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && lock_i && typ == ACC_WR && hit_any_i) |=> (resp_deny_o && resp_fault_o == 2'd1)); // R7
  AST_EX_FOREIGN_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && lock_i && typ == ACC_EX && acc_src_i != '0 && !own_ok) |=> (resp_fault_o == 2'd2)); // R9
  AST_READ_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && (typ == ACC_RD || typ == ACC_RSV)) |=> (resp_vld_o && !resp_deny_o)); // R11
  AST_FAULT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_vld_o |-> (resp_deny_o == (resp_fault_o != 2'd0))); // R11
endmodule

// File: rtl/pmr_enforcer.sv
module pmr_enforcer #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 14,
  parameter int N_CP   = 2,
  localparam int N_REG = N_CP + 1,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int PG_W  = ADDR_W - GRAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_lim_i,
  input  logic [PG_W-1:0]   cfg_pg_i,
  input  logic              boot_done_i,
  input  logic              acc_vld_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_type_i,
  input  logic              acc_priv_i,
  input  logic [IDX_W-1:0]  acc_src_i,
  output logic              resp_vld_o,
  output logic              resp_deny_o,
  output logic [1:0]        resp_fault_o,
  output logic              cfg_err_o,
  output logic              lock_o
);
  logic [PG_W-1:0]  base [N_REG];
  logic [PG_W-1:0]  lim  [N_REG];
  logic [N_REG-1:0] en;
  logic             lock, cfg_lock_wr, hit_any;
  logic [IDX_W-1:0] first_idx;
  logic [PG_W-1:0]  acc_pg;
  logic             unused_lo;

  assign acc_pg    = acc_addr_i[ADDR_W-1:GRAN_W];
  assign unused_lo = ^acc_addr_i[GRAN_W-1:0];

  pmr_cfg_regs #(.N_REG(N_REG), .IDX_W(IDX_W), .PG_W(PG_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_lim_i, .cfg_pg_i, .boot_done_i,
    .base_o(base), .lim_o(lim), .en_o(en), .lock_o(lock),
    .cfg_lock_wr_o(cfg_lock_wr), .cfg_err_o(cfg_err_o)
  );

  pmr_region_match #(.N_REG(N_REG), .IDX_W(IDX_W), .PG_W(PG_W)) u_match (
    .clk_i, .rst_ni, .base_i(base), .lim_i(lim), .en_i(en), .pg_i(acc_pg),
    .hit_any_o(hit_any), .first_idx_o(first_idx)
  );

  pmr_access_check #(.IDX_W(IDX_W)) u_chk (
    .clk_i, .rst_ni, .acc_vld_i, .acc_type_i, .acc_priv_i, .acc_src_i,
    .lock_i(lock), .hit_any_i(hit_any), .first_idx_i(first_idx),
    .cfg_lock_wr_i(cfg_lock_wr),
    .resp_vld_o, .resp_deny_o, .resp_fault_o
  );

  assign lock_o = lock;

  AST_LOCKED_CFG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && lock_o) |=> cfg_err_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_vld_i && !cfg_we_i) |=> (!resp_vld_o && !resp_deny_o)); // R11
endmodule

// File: tb/pmr_enforcer_bench.sv
module pmr_enforcer_bench;
  localparam int ADDR_W = 32;
  localparam int GRAN_W = 14;
  localparam int N_CP   = 2;
  localparam int N_REG  = N_CP + 1;
  localparam int IDX_W  = 2;
  localparam int PG_W   = ADDR_W - GRAN_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_lim_i = 0, boot_done_i = 0;
  logic [IDX_W-1:0] cfg_idx_i = '0, acc_src_i = '0;
  logic [PG_W-1:0]  cfg_pg_i = '0;
  logic acc_vld_i = 0, acc_priv_i = 0;
  logic [ADDR_W-1:0] acc_addr_i = '0;
  logic [1:0] acc_type_i = '0;
  logic resp_vld_o, resp_deny_o, cfg_err_o, lock_o;
  logic [1:0] resp_fault_o;

  int errs = 0, checks = 0;
  int m_base [N_REG];
  int m_lim  [N_REG];
  bit m_lock;

  always #2 clk_i = ~clk_i;

  pmr_enforcer #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .N_CP(N_CP)) u_pmr_enforcer (.*);

  function automatic int first_hit(int pg);
    for (int i = 0; i < N_REG; i++)
      if (m_lim[i] > m_base[i] && pg >= m_base[i] && pg < m_lim[i]) return i;
    return -1;
  endfunction

  function automatic bit overlap();
    for (int i = 0; i < N_REG; i++)
      for (int j = i + 1; j < N_REG; j++)
        if (m_lim[i] > m_base[i] && m_lim[j] > m_base[j] &&
            m_base[i] < m_lim[j] && m_base[j] < m_lim[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge: drive, predict, wait one cycle, compare at the next negedge
  task automatic step(bit we, int idx, bit lim, int pg, bit boot,
                      bit av, int apg, int typ, bit pr, int src, string tag);
    int fh, e_vld, e_deny, e_flt, e_err;
    string req;
    fh = first_hit(apg);
    e_vld = 0; e_deny = 0; e_flt = 0; req = "R11";
    if (av) begin
      e_vld = 1;
      if (!m_lock) req = "R4";
      else if (typ == 1) begin
        req = "R7";
        if (fh >= 0) begin e_deny = 1; e_flt = 1; end
      end else if (typ == 2) begin
        req = (src == 0) ? "R8" : "R9";
        if (((src == 0) ? pr : 1'b1) && fh != src) begin e_deny = 1; e_flt = 2; end
      end
    end else if (we && m_lock) begin
      e_vld = 1; e_deny = 1; e_flt = 3; req = "R6";
    end
    e_err = int'((we && m_lock) || (boot && !m_lock && overlap()));
    if (tag != "") req = tag;
    if (we && !m_lock && idx < N_REG) begin
      if (lim) m_lim[idx] = pg; else m_base[idx] = pg;
    end
    if (boot) m_lock = 1'b1;
    cfg_we_i = we; cfg_idx_i = IDX_W'(idx); cfg_lim_i = lim; cfg_pg_i = PG_W'(pg);
    boot_done_i = boot; acc_vld_i = av; acc_type_i = 2'(typ); acc_priv_i = pr;
    acc_src_i = IDX_W'(src);
    acc_addr_i = {PG_W'(apg), GRAN_W'($urandom)};
    @(negedge clk_i);
    chk(req, "resp", {resp_vld_o, resp_deny_o, resp_fault_o}, (e_vld << 3) | (e_deny << 2) | e_flt);
    chk((we || boot) ? ((we && m_lock) ? "R6" : "R10") : req, "cfg_err", cfg_err_o, e_err);
    chk("R5", "lock", lock_o, int'(m_lock));
  endtask

  task automatic acc(int apg, int typ, bit pr, int src, string tag);
    step(0, 0, 0, 0, 0, 1, apg, typ, pr, src, tag);
  endtask

  task automatic cfg(int idx, bit lim, int pg, string tag);
    step(1, idx, lim, pg, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_we_i = 0; boot_done_i = 0; acc_vld_i = 0;
    for (int i = 0; i < N_REG; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    m_lock = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1", "reset outputs", {resp_vld_o, resp_deny_o, resp_fault_o, cfg_err_o, lock_o}, 0);
  endtask

  task automatic rnd(int n, int cfg_pct, int boot_pct);
    for (int k = 0; k < n; k++) begin
      bit we, boot, av;
      we   = ($urandom % 100) < cfg_pct;
      boot = ($urandom % 1000) < boot_pct;
      av   = ($urandom % 4) != 0;
      step(we, $urandom % 4, $urandom % 2, $urandom % 48, boot,
           av, $urandom % 48, $urandom % 4, $urandom % 2, $urandom % 4, "");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    acc(10, 1, 1, 0, "R3");               // no region enabled yet
    cfg(0, 0, 8, "R2");  cfg(0, 1, 16, "R2");
    cfg(1, 0, 20, "R2"); cfg(1, 1, 24, "R2");
    cfg(2, 0, 24, "R2"); cfg(2, 1, 30, "R2");
    cfg(3, 0, 0, "R2");  cfg(3, 1, 63, "R2"); // out-of-range index ignored
    acc(10, 1, 1, 0, "R4");
    acc(40, 2, 1, 0, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    acc(40, 1, 1, 0, "R2");               // idx 3 write did not create a region
    acc(10, 1, 0, 0, "R7");
    acc(15, 1, 1, 1, "R7");
    acc(16, 1, 1, 0, "R3");               // limit is exclusive
    acc(8, 1, 1, 0, "R3");                // base is inclusive
    acc(22, 1, 1, 2, "R7");
    acc(12, 2, 1, 0, "R8");
    acc(16, 2, 1, 0, "R8");
    acc(40, 2, 0, 0, "R8");
    acc(21, 2, 0, 1, "R9");
    acc(25, 2, 1, 1, "R9");
    acc(29, 2, 0, 2, "R9");
    acc(30, 2, 0, 2, "R9");
    acc(12, 2, 1, 3, "R9");
    acc(10, 0, 0, 0, "R11");
    acc(10, 3, 0, 0, "R11");
    cfg(0, 0, 0, "R6");
    acc(5, 1, 1, 0, "R6");                // bounds unchanged after locked write
    step(1, 0, 1, 40, 0, 1, 12, 2, 1, 0, "R6"); // access and locked write together
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    rnd(400, 20, 0);

    do_reset();
    cfg(1, 0, 4, "R2");  cfg(1, 1, 12, "R2");
    cfg(2, 0, 8, "R2");  cfg(2, 1, 16, "R2");
    cfg(0, 0, 10, "R2"); cfg(0, 1, 20, "R2");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R10");
    acc(9, 2, 0, 1, "R10");
    acc(9, 2, 0, 2, "R10");
    acc(13, 2, 0, 2, "R10");
    acc(13, 2, 1, 0, "R10");
    rnd(300, 10, 0);

    do_reset();
    rnd(1500, 30, 8);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule